// File: doc/BRIEF.md
# SIMD Signed Integer to Floating-Point Converter

This block takes a 128-bit operand holding packed signed two's-complement integers. It converts every active lane into an IEEE-754 binary floating-point value of the same width and returns the packed results in a 128-bit destination word. The lanes can be 16 bits wide (converted to binary16), 32 bits wide (binary32) or 64 bits wide (binary64). The rounding mode comes from a two-bit control field with each request, so consecutive operations may round differently. The conversion is a pure integer-to-float conversion: no fraction bits are assumed and no scaling is applied.

In vector mode, the whole lower 64 bits or the whole 128 bits are converted lane by lane. In scalar mode only lane 0 is converted. The destination bits above that lane either keep the previous destination contents or are cleared, as a merge enable chooses. A request with 64-bit lanes in a 64-bit vector is not a legal configuration. It is flagged, and the held result is left untouched.

A request is a one-cycle start strobe. The packed result, an inexact flag and an illegal-configuration flag are registered and appear together with a one-cycle valid pulse in the following cycle.

Top module: `vec_sint2fp`

## Requirements
- R1: Lane width follows the size controls. With `half_sel_i`=1 the lanes are 16 bits wide, whatever the value of `size_i`. With `half_sel_i`=0, `size_i`=0 selects 32-bit lanes and `size_i`=1 selects 64-bit lanes.
- R2: In vector mode (`scalar_i`=0), the active width is 64 bits when `q_wide_i`=0 and 128 bits when `q_wide_i`=1. Every lane inside the active width is converted, and all result bits above the active width are zero.
- R3: A vector-mode request with `half_sel_i`=0, `size_i`=1 and `q_wide_i`=0 is illegal. It gives `undef_o`=1 and `inexact_o`=0 with the valid pulse, and `result_o` keeps its previous value. Every legal request gives `undef_o`=0.
- R4: In scalar mode (`scalar_i`=1) only lane 0 is converted. With `merge_en_i`=1, result bits above lane 0 equal `dest_i`. With `merge_en_i`=0, those bits are zero.
- R5: Each converted lane is the correctly rounded IEEE-754 encoding of the lane's integer value: sign bit on top, then the biased exponent, then the fraction. The fields are 1/5/10 bits for 16-bit lanes (bias 15), 1/8/23 bits for 32-bit lanes (bias 127) and 1/11/52 bits for 64-bit lanes (bias 1023). Zero converts to +0. The most negative integer converts exactly to -2^(width-1).
- R6: `rmode_i` selects the rounding: 00 rounds to nearest with ties to even, 01 rounds toward +infinity, 10 rounds toward -infinity and 11 rounds toward zero.
- R7: `inexact_o` is 1 exactly when at least one active lane's integer value cannot be represented exactly. Lanes outside the active width never set it.
- R8: `valid_o` is high for exactly one cycle, the cycle after `start_i`. `result_o`, `inexact_o` and `undef_o` hold their values until the next start.
- R9: A synchronous active-high reset clears `result_o`, `inexact_o`, `undef_o` and `valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| opnd_i | input | 128 | Packed signed integer lanes |
| dest_i | input | 128 | Old destination contents, used for scalar merge |
| half_sel_i | input | 1 | 1 selects 16-bit lanes |
| size_i | input | 1 | With half_sel_i=0: 0 selects 32-bit lanes, 1 selects 64-bit lanes |
| q_wide_i | input | 1 | Vector width: 0 is 64 bits, 1 is 128 bits |
| scalar_i | input | 1 | 1 converts lane 0 only |
| merge_en_i | input | 1 | Scalar mode: keep the destination bits above lane 0 |
| rmode_i | input | 2 | Rounding mode code |
| result_o | output | 128 | Registered packed floating-point result |
| inexact_o | output | 1 | Some active lane was rounded |
| undef_o | output | 1 | Last request was an illegal configuration |
| valid_o | output | 1 | Result strobe, one cycle after start_i |

## Verification
Every output is registered one cycle after the start strobe, so a wrong internal value shows at the ports on the valid pulse of the very request that produced it. Three kinds of internal fault are possible:
- A wrong leading-zero count, or a wrong guard/sticky split, gives a wrong exponent or fraction in the affected lane.
- A wrong active-chunk mask either leaks converted data above the active width or clears a live lane. It also lets an inactive lane set the inexact flag, or hides an active lane's inexact flag.
- A stale or badly loaded output register shows up on the next request as a result that fails to hold or fails to change.

Every 16-bit input is swept under all four rounding modes, so any error in half-precision rounding appears on the pulse of the first input it affects.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    LS_HALF   = 2'b00,
    LS_SINGLE = 2'b01,
    LS_DOUBLE = 2'b10
  } lsize_e;

  localparam int CHUNK_W = 16;

endpackage

// File: rtl/vfc_lzc.sv
module vfc_lzc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] lz_o
);

  // the highest set bit wins; an all-zero input gives W-1 (masked by the caller)
  always_comb begin
    lz_o = CW'(W - 1);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) lz_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/vfc_lane_cvt.sv
module vfc_lane_cvt
  import vfc_pkg::*;
#(
  parameter int IW = 16,
  parameter int EW = 5,
  parameter int MW = 10
) (
  input  logic [IW-1:0] int_i,
  input  rmode_e        rm_i,
  output logic [IW-1:0] fp_o,
  output logic          inexact_o
);

  localparam int CW   = $clog2(IW);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int GIDX = IW - 2 - MW;

  logic              sgn;
  logic [IW-1:0]     mag;
  logic [IW-1:0]     norm;
  logic [CW-1:0]     lz;
  logic              guard, sticky, lsb, inc;
  logic [EW-1:0]     expf;
  logic [EW+MW-1:0]  body, body_rnd;

  assign sgn = int_i[IW-1];
  assign mag = sgn ? (~int_i + 1'b1) : int_i;

  vfc_lzc #(.W(IW), .CW(CW)) u_lzc (
    .val_i (mag),
    .lz_o  (lz)
  );

  assign norm   = mag << lz;
  assign guard  = norm[GIDX];
  assign sticky = |norm[GIDX-1:0];
  assign lsb    = norm[GIDX+1];
  assign expf   = EW'(BIAS + IW - 1) - EW'(lz);
  assign body   = {expf, norm[IW-2 -: MW]};

  always_comb begin
    unique case (rm_i)
      RM_NEAREST: inc = guard & (sticky | lsb);
      RM_UP:      inc = (guard | sticky) & ~sgn;
      RM_DOWN:    inc = (guard | sticky) & sgn;
      default:    inc = 1'b0;
    endcase
  end

  // a fraction carry rolls into the exponent field on its own
  assign body_rnd  = body + {{(EW + MW - 1){1'b0}}, inc};
  assign fp_o      = (mag == '0) ? '0 : {sgn, body_rnd};
  assign inexact_o = guard | sticky;

  always_comb begin
    AST_POW2_EXACT: assert (((mag & (mag - 1'b1)) != '0) || !inexact_o); // R7
    AST_NO_INF_CODE: assert (fp_o[IW-2 -: EW] != {EW{1'b1}}); // R5
    AST_NORM_LEAD: assert ((mag == '0) || norm[IW-1]); // R5
  end

endmodule

// File: rtl/vfc_cfg_decode.sv
module vfc_cfg_decode
  import vfc_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           half_sel_i,
  input  logic           size_i,
  input  logic           q_wide_i,
  input  logic           scalar_i,
  output lsize_e         lsz_o,
  output logic           undef_o,
  output logic [NCH-1:0] act_o
);

  localparam logic [NCH-1:0] M_ONE  = NCH'(1);
  localparam logic [NCH-1:0] M_TWO  = NCH'(3);
  localparam logic [NCH-1:0] M_FOUR = NCH'(15);
  localparam logic [NCH-1:0] M_LOW  = NCH'((1 << (NCH / 2)) - 1);

  always_comb begin
    if (half_sel_i)  lsz_o = LS_HALF;
    else if (size_i) lsz_o = LS_DOUBLE;
    else             lsz_o = LS_SINGLE;
  end

  assign undef_o = ~scalar_i & ~half_sel_i & size_i & ~q_wide_i;

  always_comb begin
    if (scalar_i) begin
      unique case (lsz_o)
        LS_HALF:   act_o = M_ONE;
        LS_SINGLE: act_o = M_TWO;
        default:   act_o = M_FOUR;
      endcase
    end else begin
      act_o = q_wide_i ? '1 : M_LOW;
    end
  end

  always_comb begin
    AST_MASK_PREFIX: assert (act_o[0] && (((act_o + 1'b1) & act_o) == '0)); // R2
  end

endmodule

// File: rtl/vec_sint2fp.sv
module vec_sint2fp
  import vfc_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [VW-1:0] opnd_i,
  input  logic [VW-1:0] dest_i,
  input  logic          half_sel_i,
  input  logic          size_i,
  input  logic          q_wide_i,
  input  logic          scalar_i,
  input  logic          merge_en_i,
  input  logic [1:0]    rmode_i,
  output logic [VW-1:0] result_o,
  output logic          inexact_o,
  output logic          undef_o,
  output logic          valid_o
);

  localparam int NCH = VW / CHUNK_W;
  localparam int NH  = VW / 16;
  localparam int NS  = VW / 32;
  localparam int ND  = VW / 64;

  rmode_e          rm;
  lsize_e          lsz;
  logic            cfg_bad;
  logic [NCH-1:0]  act;
  logic [VW-1:0]   h_bus, s_bus, d_bus;
  logic [NH-1:0]   h_inx;
  logic [NS-1:0]   s_inx;
  logic [ND-1:0]   d_inx;
  logic [VW-1:0]   nxt_res;
  logic            nxt_inx;

  assign rm = rmode_e'(rmode_i);

  vfc_cfg_decode #(.NCH(NCH)) u_dec (
    .half_sel_i (half_sel_i),
    .size_i     (size_i),
    .q_wide_i   (q_wide_i),
    .scalar_i   (scalar_i),
    .lsz_o      (lsz),
    .undef_o    (cfg_bad),
    .act_o      (act)
  );

  for (genvar i = 0; i < NH; i++) begin : g_half
    vfc_lane_cvt #(.IW(16), .EW(5), .MW(10)) u_cvt (
      .int_i     (opnd_i[i*16 +: 16]),
      .rm_i      (rm),
      .fp_o      (h_bus[i*16 +: 16]),
      .inexact_o (h_inx[i])
    );
  end

  for (genvar i = 0; i < NS; i++) begin : g_single
    vfc_lane_cvt #(.IW(32), .EW(8), .MW(23)) u_cvt (
      .int_i     (opnd_i[i*32 +: 32]),
      .rm_i      (rm),
      .fp_o      (s_bus[i*32 +: 32]),
      .inexact_o (s_inx[i])
    );
  end

  for (genvar i = 0; i < ND; i++) begin : g_double
    vfc_lane_cvt #(.IW(64), .EW(11), .MW(52)) u_cvt (
      .int_i     (opnd_i[i*64 +: 64]),
      .rm_i      (rm),
      .fp_o      (d_bus[i*64 +: 64]),
      .inexact_o (d_inx[i])
    );
  end

  // per 16-bit chunk: pick the selected lane format, then mask, merge or clear
  always_comb begin
    logic [CHUNK_W-1:0] cv;
    logic               cx;
    nxt_res = '0;
    nxt_inx = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      unique case (lsz)
        LS_HALF: begin
          cv = h_bus[c*CHUNK_W +: CHUNK_W];
          cx = h_inx[c];
        end
        LS_SINGLE: begin
          cv = s_bus[c*CHUNK_W +: CHUNK_W];
          cx = s_inx[c/2];
        end
        default: begin
          cv = d_bus[c*CHUNK_W +: CHUNK_W];
          cx = d_inx[c/4];
        end
      endcase
      if (act[c])
        nxt_res[c*CHUNK_W +: CHUNK_W] = cv;
      else if (scalar_i && merge_en_i)
        nxt_res[c*CHUNK_W +: CHUNK_W] = dest_i[c*CHUNK_W +: CHUNK_W];
      nxt_inx = nxt_inx | (act[c] & cx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      inexact_o <= 1'b0;
      undef_o   <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        undef_o <= cfg_bad;
        if (cfg_bad) begin
          inexact_o <= 1'b0;
        end else begin
          result_o  <= nxt_res;
          inexact_o <= nxt_inx;
        end
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(start_i)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(result_o) && $stable(inexact_o) && $stable(undef_o)); // R8

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !scalar_i && !half_sel_i && size_i && !q_wide_i)
    |=> undef_o && !inexact_o && $stable(result_o)); // R3

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start_i && !scalar_i && !q_wide_i && (half_sel_i || !size_i))
    |=> result_o[VW-1:VW/2] == '0); // R2

  AST_MERGE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (start_i && scalar_i && merge_en_i && half_sel_i)
    |=> result_o[VW-1:16] == $past(dest_i[VW-1:16])); // R4

endmodule

// File: tb/tb_vec_sint2fp.sv
`timescale 1ns/1ps
module tb_vec_sint2fp;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] opnd = '0, dest = '0;
  logic         hs = 1'b0, sz = 1'b0, qw = 1'b0, sc = 1'b0, mg = 1'b0;
  logic [1:0]   rm = 2'b00;
  logic [127:0] result;
  logic         inexact, undef, valid;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [127:0] prev_exp = '0;
  logic [63:0]  rs = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  vec_sint2fp dut (
    .clk(clk), .rst(rst), .start_i(start), .opnd_i(opnd), .dest_i(dest),
    .half_sel_i(hs), .size_i(sz), .q_wide_i(qw), .scalar_i(sc),
    .merge_en_i(mg), .rmode_i(rm), .result_o(result), .inexact_o(inexact),
    .undef_o(undef), .valid_o(valid)
  );

  function automatic logic [63:0] nxt_rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  // reference conversion by integer arithmetic (shift and compare remainder)
  task automatic ref_cvt(input logic [63:0] raw, input int w, input logic [1:0] md,
                         output logic [63:0] fbits, output logic inx);
    int mw, bias, p, sh;
    logic [63:0] val, mag, q, rem, hlf;
    logic sgn, up;
    mw   = (w == 16) ? 10 : (w == 32) ? 23 : 52;
    bias = (w == 16) ? 15 : (w == 32) ? 127 : 1023;
    val  = (w < 64) ? (raw & ((64'd1 << w) - 1)) : raw;
    sgn  = val[w-1];
    mag  = sgn ? ((64'd1 << w) - val) : val;
    inx  = 1'b0;
    fbits = '0;
    up = 1'b0;
    if (mag == 0) return;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    if (p <= mw) begin
      q = mag << (mw - p);
    end else begin
      sh  = p - mw;
      q   = mag >> sh;
      rem = mag & ((64'd1 << sh) - 1);
      hlf = 64'd1 << (sh - 1);
      inx = (rem != 0);
      case (md)
        2'b00: up = (rem > hlf) || ((rem == hlf) && q[0]);
        2'b01: up = inx && !sgn;
        2'b10: up = inx && sgn;
        default: up = 1'b0;
      endcase
      if (up) q = q + 1;
      if (q[mw+1]) begin
        q = q >> 1;
        p = p + 1;
      end
    end
    fbits = ({63'd0, sgn} << (w - 1)) | (64'(bias + p) << mw) | (q & ((64'd1 << mw) - 1));
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic h, input logic s, input logic q, input logic scl,
                        input logic m, input logic [1:0] md,
                        input logic [127:0] op, input logic [127:0] old, input string tag);
    int w, aw;
    logic bad, e_inx, li;
    logic [63:0] fb;
    logic [127:0] e_res;
    w   = h ? 16 : (s ? 64 : 32);
    aw  = scl ? w : (q ? 128 : 64);
    bad = !scl && !h && s && !q;
    e_res = '0;
    e_inx = 1'b0;
    if (bad) begin
      e_res = prev_exp;
    end else begin
      for (int e = 0; e < aw / w; e++) begin
        ref_cvt(64'(op >> (e * w)), w, md, fb, li);
        e_res = e_res | (128'(fb) << (e * w));
        e_inx = e_inx | li;
      end
      for (int b = aw; b < 128; b++) e_res[b] = (scl && m) ? old[b] : 1'b0;
    end
    hs = h; sz = s; qw = q; sc = scl; mg = m; rm = md; opnd = op; dest = old;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(result === e_res, tag, "result", result, e_res);
    if (bad || !e_inx || inexact !== 1'b1 || undef !== 1'b0)
      chk({inexact, undef, valid} === {e_inx, bad, 1'b1}, tag, "flags inexact/undef/valid",
          128'({inexact, undef, valid}), 128'({e_inx, bad, 1'b1}));
    prev_exp = e_res;
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [127:0] op, old;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk({result, inexact, undef, valid} === '0, "R9", "reset state",
        result, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // R5 R6 R1: every 16-bit value, all rounding modes, 128-bit vectors
    for (int md = 0; md < 4; md++) begin
      for (int base = 0; base < 65536; base += 8) begin
        for (int i = 0; i < 8; i++) op[i*16 +: 16] = 16'(base + i);
        run_op(1, md[0], 1, 0, 0, 2'(md), op, '0, (md == 0) ? "R5" : "R6");
      end
    end

    // R1 R6: size_i ignored with half lanes
    op = {8{16'h7FF3}};
    run_op(1, 1, 1, 0, 0, 2'b11, op, '0, "R1");

    // R5 R6: 32-bit and 64-bit lanes, scaled random magnitudes
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 1000; k++) begin
        op = {nxt_rnd() >> (rs[5:0]), nxt_rnd() >> (rs[11:6])};
        run_op(0, 0, 1, 0, 0, 2'(md), op, '0, "R6");
        op = {nxt_rnd() >> (rs[5:0]), nxt_rnd() >> (rs[11:6])};
        run_op(0, 1, 1, 0, 0, 2'(md), op, '0, "R6");
      end
    end

    // R5: fixed encodings of the most negative values and zero
    op = {64'h8000_0000_0000_0000, 64'd0};
    run_op(0, 1, 1, 0, 0, 2'b00, op, '0, "R5");
    chk(result === {64'hC3E0_0000_0000_0000, 64'd0}, "R5", "double min/zero", result,
        {64'hC3E0_0000_0000_0000, 64'd0});
    op = {96'd0, 32'h8000_0000};
    run_op(0, 0, 1, 0, 0, 2'b01, op, '0, "R5");
    chk(result[31:0] === 32'hCF00_0000, "R5", "single min", result, 128'hCF00_0000);
    op = {112'd0, 16'h8000};
    run_op(1, 0, 1, 0, 0, 2'b10, op, '0, "R5");
    chk(result[15:0] === 16'hF800, "R5", "half min", result, 128'hF800);

    // R2 R7: 64-bit vectors, inexact upper lanes must not count
    op = {64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0004_0000_0003};
    run_op(0, 0, 0, 0, 0, 2'b00, op, '0, "R2");
    chk(inexact === 1'b0, "R7", "upper lanes ignored", 128'(inexact), 128'd0);
    op = {64'h7FF1_7FF1_7FF1_7FF1, 64'h0001_0002_0003_0005};
    run_op(1, 0, 0, 0, 0, 2'b01, op, '0, "R7");
    op = {64'h0000_0003_0000_0003, 64'h0000_0003_0100_0001};
    run_op(0, 0, 0, 0, 0, 2'b11, op, '0, "R7");

    // R4: scalar mode, merge and clear, every lane size
    for (int k = 0; k < 60; k++) begin
      op  = {nxt_rnd(), nxt_rnd() >> (rs[5:0])};
      old = {nxt_rnd(), nxt_rnd()};
      run_op(k[0], k[1], k[2], 1, k[3], 2'(k >> 4), op, old, "R4");
    end

    // R3: illegal configuration keeps result
    op = {nxt_rnd(), nxt_rnd()};
    run_op(0, 1, 0, 0, 1, 2'b00, op, {2{64'hFFFF}}, "R3");
    chk(undef === 1'b1, "R3", "undef set", 128'(undef), 128'd1);
    run_op(1, 0, 1, 0, 0, 2'b00, {8{16'h0003}}, '0, "R3");
    chk(undef === 1'b0, "R3", "undef cleared", 128'(undef), 128'd0);

    // R8: valid one cycle, outputs hold while idle
    op = {8{16'h1235}};
    run_op(1, 0, 1, 0, 0, 2'b00, op, '0, "R8");
    opnd = '1;
    @(negedge clk);
    chk(valid === 1'b0, "R8", "valid dropped", 128'(valid), 128'd0);
    chk(result === prev_exp && inexact === 1'b1, "R8", "hold while idle", result, prev_exp);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule